// File: doc/BRIEF.md
# Cache-Array Data Window

This block lets software treat the storage behind an instruction cache as ordinary data RAM. A 4 KB window can be placed on any 4 KB page of the data address space by a programmable page number. Its physical offsets always start at zero. Data reads and writes that land in the window are steered to one of six arrays, each with 256 entries, one entry per cache line. Four arrays hold 16-bit instruction words, one per word slot of the line. A fifth array holds the low 16 bits of each line's tag. A sixth array holds a small status byte per line.

The window follows the cache geometry: 256 lines of four 16-bit words, plus 16 + 8 bits of tag and status per line, which comes to 2816 bytes. Offsets 0x000 to 0x9FF map to full 16-bit storage. Offsets 0xA00 to 0xBFF map to the 8-bit status entries. Offsets 0xC00 to 0xFFF are unavailable. The window serves accesses only while the cache is disabled. At any other time it raises a flag and leaves the arrays untouched. Tag comparison and line fill logic are not part of this block.

Top module: `cwin_top`

## Requirements
- R1: An access is inside the window only when address bits [15:12] equal `win_base`. An access outside the window reads as zero, does not raise `win_unavail`, and its write has no effect on any stored location.
- R2: Offsets 0x000 to 0x7FF reach the instruction word arrays. Offset bits [10:9] select the word slot and bits [7:0] select the line. Bit 8 is ignored, so offset+0x100 is an alias of the same entry. Example: line 0x8A, word 3 sits at offset 0x68A.
- R3: Offsets 0x800 to 0x9FF reach the 16-bit low-tag entry of line bits [7:0]. Bit 8 aliases as in R2. Example: line 0x8A at 0x88A.
- R4: Offsets 0xA00 to 0xBFF reach the status byte of line bits [7:0]. Bit 8 aliases. Read bit 0 is tag bit 16, bit 1 is the line lock, and bits [5:2] are the word valid bits. A write stores `win_wdata[5:0]`. Read bits [15:6] are always zero.
- R5: Offsets 0xC00 to 0xFFF are unavailable. An access there raises `win_unavail`, reads zero, and its write is ignored.
- R6: While `cache_dis` is 0, every in-window access raises `win_unavail`, reads zero, and its write is ignored.
- R7: Read data appears on `win_rdata` in the cycle after the request. `win_rdata` is zero in any cycle that does not follow a served read.
- R8: A synchronous reset clears every array entry and `win_rdata` to zero.
- R9: `win_unavail` is combinational. It is 1 exactly when `win_req` is 1, the access is inside the window, and either the offset is at or above 0xC00 or `cache_dis` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_dis | input | 1 | 1 while the cache is disabled and the window may be used |
| win_base | input | 4 | Logical 4 KB page where the window is placed |
| win_req | input | 1 | Data access request |
| win_we | input | 1 | 1 for a write, 0 for a read |
| win_addr | input | 16 | Data address |
| win_wdata | input | 16 | Write data |
| win_rdata | output | 16 | Read data, one cycle after the request |
| win_unavail | output | 1 | Access hits the window but cannot be served |

## Verification
Some properties can be checked on every cycle without knowing what is stored:
- `win_rdata` is zero after any cycle that was not a served read.
- The top bits of a status-byte read are zero.
- `win_unavail` never coincides with a served access.
- An enabled cache always blocks in-window requests.
- Out-of-window requests never raise the flag.

Other behaviour can only be shown by the bench scenarios, which compare against a reference model of the storage:
- the offset layout and bit-8 aliasing;
- writes that are blocked while the cache is enabled, outside the window, or in the unavailable region;
- data that survives a change of the window base.

// File: rtl/cwin_pkg.sv
package cwin_pkg;

    localparam int WIN_BITS  = 12;
    localparam int LINE_W    = 8;
    localparam int NUM_LINES = 1 << LINE_W;
    localparam int WORD_W    = 16;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int STAT_W    = 6;

    typedef enum logic [1:0] {
        RG_WORD  = 2'd0,
        RG_TAGLO = 2'd1,
        RG_STAT  = 2'd2,
        RG_NONE  = 2'd3
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [SLOT_W-1:0]  slot;
        logic [LINE_W-1:0]  line;
    } dec_t;

    function automatic dec_t decode_offset(input logic [WIN_BITS-1:0] off);
        dec_t d;
        d.line = off[LINE_W-1:0];
        d.slot = off[10:9];
        case (off[11:9])
            3'd0, 3'd1, 3'd2, 3'd3: d.region = RG_WORD;
            3'd4:                   d.region = RG_TAGLO;
            3'd5:                   d.region = RG_STAT;
            default:                d.region = RG_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cwin_decode.sv
module cwin_decode
    import cwin_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int PAGE_W = ADDR_W - WIN_BITS
) (
    input  logic              req,
    input  logic              cache_dis,
    input  logic [PAGE_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic              in_win,
    output logic              acc_ok,
    output logic              unavail
);
    logic blocked;

    always_comb begin
        dec     = decode_offset(addr[WIN_BITS-1:0]);
        in_win  = req && (addr[ADDR_W-1:WIN_BITS] == base);
        blocked = (dec.region == RG_NONE) || !cache_dis;
        acc_ok  = in_win && !blocked;
        unavail = in_win && blocked;
    end
endmodule

// File: rtl/cwin_bank.sv
module cwin_bank
    import cwin_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [LINE_W-1:0] line,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[line] <= wdata;
        end
    end

    assign rdata = mem[line];
endmodule

// File: rtl/cwin_top.sv
module cwin_top
    import cwin_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int PAGE_W = ADDR_W - WIN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_dis,
    input  logic [PAGE_W-1:0] win_base,
    input  logic              win_req,
    input  logic              win_we,
    input  logic [ADDR_W-1:0] win_addr,
    input  logic [WORD_W-1:0] win_wdata,
    output logic [WORD_W-1:0] win_rdata,
    output logic              win_unavail
);
    dec_t dec;
    logic in_win, acc_ok;
    logic wr_ok, rd_ok;

    cwin_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req       (win_req),
        .cache_dis (cache_dis),
        .base      (win_base),
        .addr      (win_addr),
        .dec       (dec),
        .in_win    (in_win),
        .acc_ok    (acc_ok),
        .unavail   (win_unavail)
    );

    assign wr_ok = acc_ok && win_we;
    assign rd_ok = acc_ok && !win_we;

    logic [WORD_W-1:0] slot_rd [NUM_SLOTS];
    logic [WORD_W-1:0] taglo_rd;
    logic [STAT_W-1:0] stat_rd;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        cwin_bank #(.DATA_W(WORD_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_ok && dec.region == RG_WORD && dec.slot == SLOT_W'(s)),
            .line  (dec.line),
            .wdata (win_wdata),
            .rdata (slot_rd[s])
        );
    end

    cwin_bank #(.DATA_W(WORD_W)) u_taglo (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok && dec.region == RG_TAGLO),
        .line  (dec.line),
        .wdata (win_wdata),
        .rdata (taglo_rd)
    );

    cwin_bank #(.DATA_W(STAT_W)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok && dec.region == RG_STAT),
        .line  (dec.line),
        .wdata (win_wdata[STAT_W-1:0]),
        .rdata (stat_rd)
    );

    logic [WORD_W-1:0] rd_mux;
    always_comb begin
        case (dec.region)
            RG_WORD:  rd_mux = slot_rd[dec.slot];
            RG_TAGLO: rd_mux = taglo_rd;
            RG_STAT:  rd_mux = {{(WORD_W-STAT_W){1'b0}}, stat_rd};
            default:  rd_mux = '0;
        endcase
    end

    region_e rd_region_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            win_rdata   <= '0;
            rd_region_q <= RG_NONE;
        end else begin
            win_rdata   <= rd_ok ? rd_mux : '0;
            rd_region_q <= rd_ok ? dec.region : RG_NONE;
        end
    end

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_ok) |-> win_rdata == '0); // R7

    AST_STAT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_region_q == RG_STAT |-> win_rdata[WORD_W-1:STAT_W] == '0); // R4

    AST_UNAVAIL_NOT_SERVED: assert property (@(posedge clk) disable iff (rst)
        win_unavail |-> !acc_ok); // R5

    AST_ENABLED_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (win_req && !cache_dis && win_addr[ADDR_W-1:WIN_BITS] == win_base) |-> win_unavail); // R6

    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (win_req && win_addr[ADDR_W-1:WIN_BITS] != win_base) |-> (!win_unavail && !acc_ok)); // R1

    AST_HIGH_REGION_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (in_win && win_addr[11:10] == 2'b11) |-> win_unavail); // R9
endmodule

// File: tb/cwin_top_tb.sv
module cwin_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst;
    logic        cache_dis;
    logic [3:0]  win_base;
    logic        win_req;
    logic        win_we;
    logic [15:0] win_addr;
    logic [15:0] win_wdata;
    logic [15:0] win_rdata;
    logic        win_unavail;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] ref_m [4096];

    always #(CLK_PERIOD/2) clk = ~clk;

    cwin_top dut_i (
        .clk(clk), .rst(rst), .cache_dis(cache_dis), .win_base(win_base),
        .win_req(win_req), .win_we(win_we), .win_addr(win_addr),
        .win_wdata(win_wdata), .win_rdata(win_rdata), .win_unavail(win_unavail)
    );

    function automatic logic [11:0] canon(input logic [11:0] off);
        return {off[11:9], 1'b0, off[7:0]};
    endfunction

    function automatic string req_of(input logic in_w, input logic dis, input logic [11:0] off);
        if (!in_w) return "R1";
        if (!dis) return "R6";
        if (off < 12'h800) return "R2";
        if (off < 12'hA00) return "R3";
        if (off < 12'hC00) return "R4";
        return "R5";
    endfunction

    task automatic check(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [15:0] addr, input logic [15:0] wd, input logic dis);
        logic        in_w;
        logic        ok;
        logic [11:0] off;
        logic [15:0] exp_rd;
        string       rq;
        off  = addr[11:0];
        in_w = (addr[15:12] == win_base);
        ok   = in_w && dis && (off < 12'hC00);
        rq   = req_of(in_w, dis, off);
        exp_rd = 16'h0;
        if (ok && !we) exp_rd = (off >= 12'hA00) ? (ref_m[canon(off)] & 16'h003F) : ref_m[canon(off)];
        @(negedge clk);
        win_req = 1; win_we = we; win_addr = addr; win_wdata = wd; cache_dis = dis;
        #1;
        check((!in_w || dis) && off < 12'hC00 ? rq : "R9", "unavail", {15'b0, win_unavail},
              {15'b0, in_w && (!dis || off >= 12'hC00)});
        @(negedge clk);
        win_req = 0;
        check(we ? "R7" : rq, we ? "rdata after write" : "read data", win_rdata, exp_rd);
        if (ok && we) ref_m[canon(off)] = (off >= 12'hA00) ? (wd & 16'h003F) : wd;
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) ref_m[i] = '0;
        rst = 1; cache_dis = 1; win_base = 4'h3; win_req = 0; win_we = 0;
        win_addr = '0; win_wdata = '0;
        repeat (3) @(negedge clk);
        check("R8", "rdata in reset", win_rdata, 16'h0);
        rst = 0;
        check("R8", "rdata after reset", win_rdata, 16'h0);
        do_op(0, 16'h3000, 0, 1);
        do_op(0, 16'h368A, 0, 1);
        do_op(0, 16'h3A8A, 0, 1);

        // R2 word slot layout and alias
        do_op(1, 16'h368A, 16'hBEEF, 1);
        do_op(0, 16'h368A, 0, 1);
        do_op(0, 16'h378A, 0, 1);
        do_op(0, 16'h348A, 0, 1);
        // R3 low tag
        do_op(1, 16'h388A, 16'h1234, 1);
        do_op(0, 16'h398A, 0, 1);
        // R4 status byte masking
        do_op(1, 16'h3A8A, 16'hFFFF, 1);
        do_op(0, 16'h3A8A, 0, 1);
        do_op(0, 16'h3B8A, 0, 1);
        // R5 unavailable region
        do_op(1, 16'h3C10, 16'h5555, 1);
        do_op(0, 16'h3C10, 0, 1);
        do_op(0, 16'h3010, 0, 1);
        // R6 enabled cache blocks access
        do_op(1, 16'h368A, 16'h0BAD, 0);
        do_op(0, 16'h368A, 0, 0);
        do_op(0, 16'h368A, 0, 1);
        // R1 outside window
        do_op(1, 16'h468A, 16'h7777, 1);
        do_op(0, 16'h468A, 0, 1);
        do_op(0, 16'h368A, 0, 1);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  pg;
            logic [15:0] a;
            if (i == 1500) win_base = 4'hA;
            pg = ($urandom % 5 == 0) ? 4'($urandom) : win_base;
            a  = {pg, 12'($urandom)};
            if ($urandom % 3 == 0) a[11:0] = {3'($urandom % 6), 1'($urandom), 8'($urandom % 4)};
            do_op(1'($urandom), a, 16'($urandom), ($urandom % 8) != 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule